// File: doc/BRIEF.md
# Triggered Dual-Channel PWM Fader

This block drives two PWM outputs whose duty cycle fades smoothly on command from a single trigger input. A rising trigger edge ramps both channels up toward a programmed maximum duty. A falling edge ramps them down toward a programmed minimum. Channel 0 starts after its own programmable delay. Channel 1 follows it after a second, shared delay, which produces a sequential turn-on effect. Each ramp walks a fixed 176-entry brightness curve. It advances one curve entry per step period, and the step period is set by a rate parameter, with one rate for fading in and another for fading out.

A host configures the block through a plain synchronous register port. Seven parameter words sit in a small store that the host reaches indirectly: it writes a parameter index to an index register and then reads or writes the word through a data register. A two-bit engine control register gates the whole sequencer. The trigger input must be synchronous to `clk`.

Top module: `pwm_fader`

## Requirements
- R1: Writing register 0x2B sets the parameter index and reading it returns that index. Register 0x2C reads and writes the 16-bit parameter at the current index. Indices 0x20..0x26 are valid. A write to 0x2C with any other index is ignored, and a read of 0x2C with such an index returns 0.
- R2: Register 0x27 bits [1:0] form the engine control and reset to 3. The engine runs only while both bits are 1. While it is stopped, trigger edges are ignored and the channels keep their curve position. Re-enabling the engine never starts a ramp without a new trigger edge.
- R3: The brightness curve has indices 0..175, and duty(i) = floor(i*i*127/30625). The channel index never leaves this range.
- R4: A rising trigger edge makes each channel step its index upward. The ramp stops at the first index whose duty is at least the maximum, taken from bits [6:0] of parameter 0x21, or at index 175.
- R5: A falling trigger edge makes each channel step its index downward. The ramp stops at the first index whose duty is at most the minimum, taken from bits [6:0] of parameter 0x20, or at index 0.
- R6: During a ramp the index moves by one entry every max(rate,1)*STEP_PRESCALE clocks. The rate is parameter 0x23 when rising and parameter 0x26 when falling.
- R7: Channel 0 starts ramping D0*DELAY_PRESCALE clocks after the edge. Channel 1 starts (D0+DC)*DELAY_PRESCALE clocks after the edge. D0 is parameter 0x24 and DC is parameter 0x25.
- R8: A new edge cancels any pending start and reloads the delays, and the index moves by at most one entry per clock. A reversed ramp therefore continues from the current duty without a jump.
- R9: A shared PWM counter runs from 0 to 126. It advances every (32-code)*PWM_PRESCALE clocks, where code is bits [11:7] of parameter 0x22. An output is high while the counter is below that channel's duty, so the period is 127*(32-code)*PWM_PRESCALE clocks.
- R10: A channel takes up a new duty only when the counter wraps to 0. A duty of 0 holds the output low, and a duty of 127 holds it high.
- R11: After reset both outputs are low, both indices are 0 and all parameters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Fade trigger: rising edge fades in, falling edge fades out |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| pwm_out | output | NCH (2) | PWM outputs, one per channel |

## Verification
The bench reverses the trigger in the middle of a ramp and checks that the duty measured during the new start delay lies strictly between 0 and 127. A design that snapped to the target would show 0 or 127 there. It also issues an edge inside a pending start delay and then reverses it, which catches a design that lets the cancelled ramp run. With a long common delay it measures channel 1 still dark while channel 0 is already at full duty, which exposes delays that are not chained. It toggles the trigger while the engine is stopped and then re-enables the engine, so a design that latched a stale edge would light up. Random limits and rates, including a minimum above the maximum, are compared against the curve-walk model after each ramp.

// File: rtl/pwm_fader_pkg.sv
`timescale 1ns/1ps
package pwm_fader_pkg;
    localparam int DUTY_W = 7;
    localparam int IDX_W  = 8;
    localparam int WORD_W = 16;
    localparam int STEPS  = 176;
    localparam int LAST   = STEPS - 1;
    localparam int CNT_TOP = (1 << DUTY_W) - 2;

    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_RAMP} phase_e;

    // Quadratic brightness curve, monotonic, 0 at index 0 and 127 at LAST
    function automatic logic [DUTY_W-1:0] curve(input logic [IDX_W-1:0] i);
        logic [31:0] p;
        p = (32'(i) * 32'(i) * 32'd127) / 32'(LAST * LAST);
        return p[DUTY_W-1:0];
    endfunction
endpackage

// File: rtl/pwm_fader_regs.sv
`timescale 1ns/1ps
module pwm_fader_regs
    import pwm_fader_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              run,
    output logic [DUTY_W-1:0] pmin,
    output logic [DUTY_W-1:0] pmax,
    output logic [4:0]        fcode,
    output logic [WORD_W-1:0] rate_up,
    output logic [WORD_W-1:0] rate_dn,
    output logic [WORD_W-1:0] dly0,
    output logic [WORD_W-1:0] dlyc
);
    localparam int NWORDS = 7;
    localparam int OFF_W  = $clog2(NWORDS);
    localparam logic [AW-1:0] BASE   = AW'(8'h20);
    localparam logic [AW-1:0] A_CTRL = AW'(8'h27);
    localparam logic [AW-1:0] A_SEL  = AW'(8'h2B);
    localparam logic [AW-1:0] A_DATA = AW'(8'h2C);

    typedef struct packed {
        logic [AW-1:0]                  sel;
        logic [1:0]                     ctrl;
        logic [NWORDS-1:0][WORD_W-1:0]  words;
    } regs_t;

    regs_t s_d, s_q;
    logic              hit;
    logic [AW-1:0]     rel;
    logic [OFF_W-1:0]  off;

    always_comb begin
        rel = s_q.sel - BASE;
        off = rel[OFF_W-1:0];
        hit = (s_q.sel >= BASE) && (rel < AW'(NWORDS));
        s_d = s_q;
        if (wr_en) begin
            case (addr)
                A_SEL:  s_d.sel = wdata[AW-1:0];
                A_DATA: if (hit) s_d.words[off] = wdata;
                A_CTRL: s_d.ctrl = wdata[1:0];
                default: ;
            endcase
        end
        case (addr)
            A_SEL:   rdata = WORD_W'(s_q.sel);
            A_DATA:  rdata = hit ? s_q.words[off] : '0;
            A_CTRL:  rdata = WORD_W'(s_q.ctrl);
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ctrl <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    assign run     = &s_q.ctrl;
    assign pmin    = s_q.words[0][DUTY_W-1:0];
    assign pmax    = s_q.words[1][DUTY_W-1:0];
    assign fcode   = s_q.words[2][11:7];
    assign rate_up = s_q.words[3];
    assign dly0    = s_q.words[4];
    assign dlyc    = s_q.words[5];
    assign rate_dn = s_q.words[6];
endmodule

// File: rtl/pwm_fader_chan.sv
`timescale 1ns/1ps
module pwm_fader_chan
    import pwm_fader_pkg::*;
#(
    parameter int CNT_W         = 48,
    parameter int STEP_PRESCALE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rise,
    input  logic              fall,
    input  logic [CNT_W-1:0]  delay,
    input  logic [WORD_W-1:0] rate_up,
    input  logic [WORD_W-1:0] rate_dn,
    input  logic [DUTY_W-1:0] pmax,
    input  logic [DUTY_W-1:0] pmin,
    output logic [IDX_W-1:0]  idx
);
    typedef struct packed {
        phase_e            ph;
        logic              up;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
    } chan_t;

    chan_t s_d, s_q;
    logic [WORD_W-1:0] rate;
    logic [CNT_W-1:0]  step_len;
    logic [DUTY_W-1:0] cur;
    logic              at_goal;

    always_comb begin
        rate     = s_q.up ? rate_up : rate_dn;
        step_len = CNT_W'((rate == '0) ? WORD_W'(1) : rate) * CNT_W'(STEP_PRESCALE);
        cur      = curve(s_q.idx);
        at_goal  = s_q.up ? ((s_q.idx == IDX_W'(LAST)) || (cur >= pmax))
                          : ((s_q.idx == '0) || (cur <= pmin));
        s_d = s_q;
        if (!run) begin
            s_d.ph = PH_IDLE;
        end else if (rise || fall) begin
            s_d.ph  = PH_WAIT;
            s_d.up  = rise;
            s_d.cnt = delay;
        end else begin
            case (s_q.ph)
                PH_WAIT: begin
                    if (s_q.cnt == '0) begin
                        s_d.ph  = PH_RAMP;
                        s_d.cnt = step_len;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                PH_RAMP: begin
                    if (at_goal) begin
                        s_d.ph = PH_IDLE;
                    end else if (s_q.cnt <= CNT_W'(1)) begin
                        s_d.idx = s_q.up ? s_q.idx + 1'b1 : s_q.idx - 1'b1;
                        s_d.cnt = step_len;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx = s_q.idx;
endmodule

// File: rtl/pwm_fader_pwm.sv
`timescale 1ns/1ps
module pwm_fader_pwm
    import pwm_fader_pkg::*;
#(
    parameter int NCH          = 2,
    parameter int PWM_PRESCALE = 64,
    parameter int DIV_W        = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [4:0]                   fcode,
    input  logic [NCH-1:0][IDX_W-1:0]    idx,
    output logic [NCH-1:0]               pwm,
    output logic [DUTY_W-1:0]            cnt,
    output logic [NCH-1:0][DUTY_W-1:0]   duty
);
    typedef struct packed {
        logic [DIV_W-1:0]               div;
        logic [DUTY_W-1:0]              cnt;
        logic [NCH-1:0][DUTY_W-1:0]     duty;
    } pwm_t;

    pwm_t s_d, s_q;
    logic [DIV_W-1:0] reload;

    always_comb begin
        reload = DIV_W'(6'd32 - {1'b0, fcode}) * DIV_W'(PWM_PRESCALE) - 1'b1;
        s_d = s_q;
        if (s_q.div == '0) begin
            s_d.div = reload;
            if (s_q.cnt == DUTY_W'(CNT_TOP)) begin
                s_d.cnt = '0;
                for (int k = 0; k < NCH; k++) s_d.duty[k] = curve(idx[k]);
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.div = s_q.div - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_out
        assign pwm[k] = (s_q.cnt < s_q.duty[k]);
    end

    assign cnt  = s_q.cnt;
    assign duty = s_q.duty;
endmodule

// File: rtl/pwm_fader.sv
`timescale 1ns/1ps
module pwm_fader
    import pwm_fader_pkg::*;
#(
    parameter int NCH            = 2,
    parameter int STEP_PRESCALE  = 16,
    parameter int DELAY_PRESCALE = 2366 * STEP_PRESCALE,
    parameter int PWM_PRESCALE   = 64,
    parameter int CNT_W          = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic [NCH-1:0]     pwm_out
);
    localparam int DIV_W = 6 + $clog2(PWM_PRESCALE + 1);

    typedef struct packed {
        logic trig;
    } top_t;

    top_t t_d, t_q;
    logic rise, fall, run;
    logic [DUTY_W-1:0] pmin, pmax, pwm_cnt;
    logic [4:0]        fcode;
    logic [WORD_W-1:0] rate_up, rate_dn, dly0, dlyc;
    logic [NCH-1:0][IDX_W-1:0]  idx;
    logic [NCH-1:0][DUTY_W-1:0] duty;
    logic [NCH-1:0][CNT_W-1:0]  dly;

    always_comb begin
        t_d.trig = trig;
        rise = trig & ~t_q.trig;
        fall = ~trig & t_q.trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    pwm_fader_regs #(.AW(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .run(run), .pmin(pmin),
        .pmax(pmax), .fcode(fcode), .rate_up(rate_up), .rate_dn(rate_dn),
        .dly0(dly0), .dlyc(dlyc)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign dly[k] = (CNT_W'(dly0) + CNT_W'(k) * CNT_W'(dlyc)) * CNT_W'(DELAY_PRESCALE);

        pwm_fader_chan #(.CNT_W(CNT_W), .STEP_PRESCALE(STEP_PRESCALE)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(run), .rise(rise), .fall(fall),
            .delay(dly[k]), .rate_up(rate_up), .rate_dn(rate_dn),
            .pmax(pmax), .pmin(pmin), .idx(idx[k])
        );
    end

    pwm_fader_pwm #(.NCH(NCH), .PWM_PRESCALE(PWM_PRESCALE), .DIV_W(DIV_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .fcode(fcode), .idx(idx),
        .pwm(pwm_out), .cnt(pwm_cnt), .duty(duty)
    );
endmodule

// File: rtl/pwm_fader_chk.sv
`timescale 1ns/1ps
module pwm_fader_chk
    import pwm_fader_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        run,
    input logic [NCH-1:0]              pwm,
    input logic [DUTY_W-1:0]           cnt,
    input logic [NCH-1:0][DUTY_W-1:0]  duty,
    input logic [NCH-1:0][IDX_W-1:0]   idx
);
    for (genvar k = 0; k < NCH; k++) begin : g_a
        a_r10_duty_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != '0) |-> $stable(duty[k]));
        a_r10_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
            (duty[k] == '0) |-> !pwm[k]);
        a_r10_full_high: assert property (@(posedge clk) disable iff (!rst_n)
            (duty[k] == DUTY_W'(127)) |-> pwm[k]);
        a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
            32'(idx[k]) <= LAST);
        a_r2_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> $stable(idx[k]));
        a_r8_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
            (idx[k] != $past(idx[k])) |->
            ((9'(idx[k]) == 9'($past(idx[k])) + 9'd1) ||
             (9'(idx[k]) + 9'd1 == 9'($past(idx[k])))));
    end
endmodule

bind pwm_fader pwm_fader_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .pwm(pwm_out),
    .cnt(pwm_cnt), .duty(duty), .idx(idx)
);

// File: tb/pwm_fader_tb.sv
`timescale 1ns/1ps
module pwm_fader_tb;
    localparam int DP = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_fader #(.NCH(2), .STEP_PRESCALE(1), .DELAY_PRESCALE(DP), .PWM_PRESCALE(1), .CNT_W(48)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    function automatic int lutb(int i);
        return (i * i * 127) / (175 * 175);
    endfunction

    function automatic int up_to(int s, int mx);
        int i = s;
        while (i < 175 && lutb(i) < mx) i++;
        return i;
    endfunction

    function automatic int dn_to(int s, int mn);
        int i = s;
        while (i > 0 && lutb(i) > mn) i--;
        return i;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setp(input logic [7:0] i, input logic [15:0] v);
        wr(8'h2B, {8'h00, i});
        wr(8'h2C, v);
    endtask

    task automatic meas(input int ch, input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            h += int'(pwm_out[ch]);
        end
    endtask

    function automatic int settle(int d0, int dc, int rate, int div);
        int r = (rate < 1) ? 1 : rate;
        return (d0 + dc) * DP + 177 * r + 2 * 127 * div + 50;
    endfunction

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int h, h1, m_idx, mx, mn, rt, d0, dc;
        void'($urandom(32'd2024));
        clks(5);
        rst_n = 1'b1;
        clks(2);

        // Reset state
        meas(0, 127, h);  chk(h == 0, "R11 ch0 low after reset", h, 0);
        meas(1, 127, h);  chk(h == 0, "R11 ch1 low after reset", h, 0);
        rd(8'h27, d);     chk(d == 16'h3, "R2 ctrl reset", d, 3);
        wr(8'h2B, 16'h21);
        rd(8'h2C, d);     chk(d == 0, "R11 param reset", d, 0);

        // Indirect access
        setp(8'h22, 16'(31 << 7));
        rd(8'h2C, d);     chk(d == 16'h0F80, "R1 data readback", d, 16'h0F80);
        rd(8'h2B, d);     chk(d == 16'h22, "R1 index readback", d, 16'h22);
        setp(8'h30, 16'hBEEF);
        rd(8'h2C, d);     chk(d == 0, "R1 invalid index read", d, 0);
        for (int i = 8'h20; i <= 8'h26; i++) begin
            wr(8'h2B, 16'(i));
            rd(8'h2C, d);
            chk(d == ((i == 8'h22) ? 16'h0F80 : 16'h0), "R1 invalid write ignored", d, (i == 8'h22) ? 16'h0F80 : 0);
        end

        // Full fade in and out
        setp(8'h21, 16'h007F); setp(8'h20, 16'h0000);
        setp(8'h23, 16'd4);    setp(8'h26, 16'd4);
        setp(8'h24, 16'd0);    setp(8'h25, 16'd0);
        trig = 1'b1; clks(settle(0, 0, 4, 1));
        m_idx = up_to(0, 127);
        meas(0, 127, h);  chk(h == 127, "R4 R10 ch0 full high", h, 127);
        meas(1, 127, h);  chk(h == 127, "R4 ch1 full high", h, 127);
        trig = 1'b0; clks(settle(0, 0, 4, 1));
        m_idx = dn_to(m_idx, 0);
        meas(0, 127, h);  chk(h == 0, "R5 R10 ch0 low", h, 0);
        meas(1, 127, h);  chk(h == 0, "R5 ch1 low", h, 0);

        // Step period
        setp(8'h23, 16'd10);
        trig = 1'b1; clks(700);
        meas(0, 127, h);  chk(h > 0 && h < 127, "R6 mid ramp at rate 10", h, 64);
        clks(settle(0, 0, 10, 1));
        meas(0, 127, h);  chk(h == 127, "R6 ramp complete", h, 127);
        trig = 1'b0; clks(settle(0, 0, 4, 1));
        m_idx = 15;

        // Staggered starts
        setp(8'h23, 16'd5); setp(8'h24, 16'd20); setp(8'h25, 16'd30);
        trig = 1'b1; clks(600);
        meas(0, 127, h);  chk(h == 0, "R7 ch0 waits d0", h, 0);
        clks(2400 - 727);
        meas(0, 127, h);  chk(h == 127, "R7 ch0 ramped", h, 127);
        meas(1, 127, h);  chk(h == 0, "R7 ch1 still waiting", h, 0);
        clks(2000);
        meas(1, 127, h);  chk(h == 127, "R7 ch1 ramped", h, 127);
        setp(8'h24, 16'd0); setp(8'h25, 16'd0);
        trig = 1'b0; clks(settle(0, 0, 4, 1));

        // Reversal mid ramp
        setp(8'h23, 16'd20); setp(8'h24, 16'd2); setp(8'h25, 16'd20);
        trig = 1'b1; clks(1828);
        trig = 1'b0;
        meas(0, 127, h);  chk(h > 0 && h < 127, "R8 ch0 no jump on reversal", h, 64);
        meas(1, 127, h1); chk(h1 > 0 && h1 < 127, "R8 ch1 no jump on reversal", h1, 5);
        clks(settle(2, 20, 4, 1));
        meas(0, 127, h);  chk(h == 0, "R8 reversed ch0 at min", h, 0);
        meas(1, 127, h);  chk(h == 0, "R8 reversed ch1 at min", h, 0);

        // Pending start cancelled
        setp(8'h24, 16'd10); setp(8'h25, 16'd0);
        trig = 1'b1; clks(100);
        trig = 1'b0; clks(1400);
        meas(0, 127, h);  chk(h == 0, "R8 pending start cancelled", h, 0);
        setp(8'h24, 16'd0);
        setp(8'h23, 16'd4);

        // Engine stopped
        wr(8'h27, 16'h0);
        trig = 1'b1; clks(settle(0, 0, 4, 1));
        meas(0, 127, h);  chk(h == 0, "R2 edge ignored while stopped", h, 0);
        wr(8'h27, 16'h1); clks(settle(0, 0, 4, 1));
        meas(0, 127, h);  chk(h == 0, "R2 one bit does not run", h, 0);
        wr(8'h27, 16'h3); clks(settle(0, 0, 4, 1));
        meas(1, 127, h);  chk(h == 0, "R2 no ramp without edge", h, 0);
        trig = 1'b0; clks(20);
        trig = 1'b1; clks(settle(0, 0, 4, 1));
        meas(1, 127, h);  chk(h == 127, "R2 runs again after enable", h, 127);
        trig = 1'b0; clks(settle(0, 0, 4, 1));
        m_idx = 15;

        // PWM frequency code 30 and mid target
        setp(8'h22, 16'(30 << 7)); setp(8'h21, 16'd64);
        trig = 1'b1; clks(settle(0, 0, 4, 2));
        m_idx = up_to(m_idx, 64);
        meas(0, 254, h);  chk(h == 2 * lutb(m_idx), "R9 R4 code 30 period", h, 2 * lutb(m_idx));
        setp(8'h22, 16'(31 << 7));
        trig = 1'b0; clks(settle(0, 0, 4, 2));
        m_idx = dn_to(m_idx, 0);

        // Random limits, rates and delays
        for (int it = 0; it < 8; it++) begin
            mx = int'($urandom_range(0, 127));
            mn = int'($urandom_range(0, 127));
            rt = int'($urandom_range(0, 12));
            d0 = int'($urandom_range(0, 3));
            dc = int'($urandom_range(0, 3));
            setp(8'h21, 16'(mx)); setp(8'h20, 16'(mn));
            setp(8'h23, 16'(rt)); setp(8'h26, 16'(rt));
            setp(8'h24, 16'(d0)); setp(8'h25, 16'(dc));
            trig = 1'b1; clks(settle(d0, dc, rt, 1));
            m_idx = up_to(m_idx, mx);
            meas(0, 127, h);  chk(h == lutb(m_idx), "R4 random fade-in ch0", h, lutb(m_idx));
            meas(1, 127, h);  chk(h == lutb(m_idx), "R4 random fade-in ch1", h, lutb(m_idx));
            trig = 1'b0; clks(settle(d0, dc, rt, 1));
            m_idx = dn_to(m_idx, mn);
            meas(0, 127, h);  chk(h == lutb(m_idx), "R5 R3 random fade-out ch0", h, lutb(m_idx));
            meas(1, 127, h);  chk(h == lutb(m_idx), "R5 random fade-out ch1", h, lutb(m_idx));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule